// File: doc/BRIEF.md
# Sector-Buffered Transfer Engine

This block sits between a processor's byte-wide data port and a slow storage device. It moves the data phase of a disk-style transfer through a single sector buffer in either direction. A start pulse loads a signed count of the bytes that remain. On the read side it asks storage for a sector of fill data and then hands the buffered bytes to the processor one at a time. When a full sector has been consumed it asks for the next one. On the write side it collects processor bytes into the buffer and asks storage to take each full sector.

The processor side uses a level request with a one-cycle acknowledge. Storage talks to the block over two request/acknowledge channels. The fill channel streams bytes into the buffer. The flush channel lets storage read buffer bytes at any address it chooses. The block drives a REQ indication, a one-shot next-REQ flag that a status read clears, and a status byte that carries a transfer-end bit, a DMA bit and a phase-match bit.

Top module: `sb_xfer`

## Requirements
- R1: After reset, `ack_o`, `fill_req_o`, `flush_req_o` and `req_o` are 0, and `bas_o` is 0x00 while `dma_mode_i` is 0.
- R2: A read is served from the buffer when `phase_i` is 1 (data-in) or when `dma_mode_i` is 1. In any other case the read is acknowledged with data 0x00 and the buffer pointer does not move.
- R3: When the remaining count is below the sector size, each read advances the pointer only while it is below count−1. A read at that limit returns the same last byte and sets the next-REQ flag. The flag forces `req_o` low until a `stat_rd_i` pulse clears it.
- R4: A start with a count between 1 and sector size−1 clears the buffer byte at the index equal to the count.
- R5: When the remaining count is at least one sector, reading byte 511 subtracts 512 from the count, wraps the pointer to 0 and sets next-REQ. If the new count is still positive, it raises `fill_req_o` with `fill_len_o` = min(count, 512).
- R6: If a sector wrap on the read side leaves a count of 0 or less, the block clears REQ and the phase-match bit (bit 3 of `bas_o`). In DMA mode it also sets the transfer-end bit (bit 7).
- R7: While `fill_req_o` is high, reads and writes are not acknowledged and `req_o` is low.
- R8: A write is stored at the pointer only when `phase_i` is 0 (data-out) and `init_cmd_i` equals 0x01. Any other write is acknowledged and leaves the buffer unchanged.
- R9: Storing byte 511 raises `flush_req_o`, subtracts 512 from the count and resets the pointer. Writes stall until `flush_ack_i`.
- R10: If a write flush leaves a count of 0 or less, `bas_o` becomes 0xC8 (bits 7, 6 and 3 set).
- R11: A start pulse raises `req_o` (unless a fill is pending) and sets `bas_o` to 0x08 while `dma_mode_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Load count and begin a transfer |
| start_len_i | input | LEN_W | Signed byte count for the transfer |
| start_rd_i | input | 1 | 1 = read transfer, which requests an initial fill |
| phase_i | input | 3 | Bus phase code (0 data-out, 1 data-in) |
| dma_mode_i | input | 1 | DMA mode active |
| init_cmd_i | input | 8 | Initiator command value; 0x01 enables write capture |
| rd_req_i | input | 1 | Processor read request (level) |
| wr_req_i | input | 1 | Processor write request (level) |
| wr_data_i | input | DATA_W | Processor write byte |
| ack_o | output | 1 | One-cycle acknowledge of a read or write |
| rd_data_o | output | DATA_W | Read byte, valid with ack_o |
| stat_rd_i | input | 1 | Status read pulse that clears next-REQ |
| req_o | output | 1 | REQ indication |
| bas_o | output | 8 | Status: bit7 end, bit6 DMA, bit3 phase match |
| fill_req_o | output | 1 | Fill request to storage |
| fill_len_o | output | CNT_W | Byte count of requested fill |
| fill_valid_i | input | 1 | Fill byte strobe |
| fill_data_i | input | DATA_W | Fill byte |
| fill_ack_i | input | 1 | Fill complete |
| flush_req_o | output | 1 | Full sector ready for storage |
| flush_addr_i | input | PTR_W | Buffer address storage reads |
| flush_data_o | output | DATA_W | Buffer byte at flush_addr_i |
| flush_ack_i | input | 1 | Flush complete |

## Verification
A wrong pointer shows up in the very next acknowledged read, as a byte that does not match the fill pattern at the expected index. A wrong count only shows up later, at the sector boundary: the refill length is wrong, or the end-of-transfer status bits flip too early or never. A stuck next-REQ flag or stuck pending fill holds `req_o` low, and a stuck pending flush stops write acknowledges within a cycle. Buffer corruption from an ignored write or a missing pad byte is visible at once through the flush read port.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [2:0] {
        PH_DATA_OUT = 3'd0,
        PH_DATA_IN  = 3'd1
    } phase_e;

    localparam int BAS_END_BIT = 7;
    localparam int BAS_DMA_BIT = 6;
    localparam int BAS_PM_BIT  = 3;
    localparam logic [7:0] INIT_DRIVE_DATA = 8'h01;
endpackage

// File: rtl/sb_buffer.sv
module sb_buffer #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              a_we_i,
    input  logic [AW-1:0]     a_addr_i,
    input  logic [DATA_W-1:0] a_data_i,
    input  logic              b_we_i,
    input  logic [AW-1:0]     b_addr_i,
    input  logic [DATA_W-1:0] b_data_i,
    input  logic [AW-1:0]     r0_addr_i,
    output logic [DATA_W-1:0] r0_data_o,
    input  logic [AW-1:0]     r1_addr_i,
    output logic [DATA_W-1:0] r1_data_o
);
    logic [DATA_W-1:0] mem [DEPTH];

    // port a (processor side) wins over port b (fill side)
    always_ff @(posedge clk) begin
        if (a_we_i) begin
            mem[a_addr_i] <= a_data_i;
        end else if (b_we_i) begin
            mem[b_addr_i] <= b_data_i;
        end
    end

    assign r0_data_o = mem[r0_addr_i];
    assign r1_data_o = mem[r1_addr_i];
endmodule

// File: rtl/sb_storage_if.sv
module sb_storage_if #(
    parameter int SECT_BYTES = 512,
    parameter int DATA_W     = 8,
    localparam int PTR_W     = $clog2(SECT_BYTES),
    localparam int CNT_W     = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_start_i,
    input  logic [CNT_W-1:0]  fill_len_i,
    input  logic              fill_valid_i,
    input  logic [DATA_W-1:0] fill_data_i,
    input  logic              fill_ack_i,
    input  logic              flush_start_i,
    input  logic              flush_ack_i,
    output logic              fill_req_o,
    output logic [CNT_W-1:0]  fill_len_o,
    output logic              flush_req_o,
    output logic              mem_we_o,
    output logic [PTR_W-1:0]  mem_waddr_o,
    output logic [DATA_W-1:0] mem_wdata_o
);
    typedef struct packed {
        logic             fill_pend;
        logic [CNT_W-1:0] fill_len;
        logic [PTR_W-1:0] fill_addr;
        logic             flush_pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        mem_we_o    = 1'b0;
        mem_waddr_o = st_q.fill_addr;
        mem_wdata_o = fill_data_i;
        if (st_q.fill_pend && fill_valid_i) begin
            mem_we_o       = 1'b1;
            st_d.fill_addr = st_q.fill_addr + 1'b1;
        end
        if (st_q.fill_pend && fill_ack_i) begin
            st_d.fill_pend = 1'b0;
        end
        if (fill_start_i) begin
            st_d.fill_pend = 1'b1;
            st_d.fill_len  = fill_len_i;
            st_d.fill_addr = '0;
        end
        if (flush_ack_i) begin
            st_d.flush_pend = 1'b0;
        end
        if (flush_start_i) begin
            st_d.flush_pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fill_req_o  = st_q.fill_pend;
    assign fill_len_o  = st_q.fill_len;
    assign flush_req_o = st_q.flush_pend;

    // R5: never fill and flush at the same time
    p_one_channel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.fill_pend, st_q.flush_pend}));

    // R5: a fill request carries a nonzero length no larger than a sector
    p_fill_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill_pend |-> (st_q.fill_len != '0 && st_q.fill_len <= CNT_W'(SECT_BYTES)));
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sb_pkg::*;
#(
    parameter int SECT_BYTES = 512,
    parameter int DATA_W     = 8,
    parameter int LEN_W      = 24,
    localparam int PTR_W     = $clog2(SECT_BYTES),
    localparam int CNT_W     = PTR_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic signed [LEN_W-1:0] start_len_i,
    input  logic                    start_rd_i,
    input  logic [2:0]              phase_i,
    input  logic                    dma_mode_i,
    input  logic [7:0]              init_cmd_i,
    input  logic                    rd_req_i,
    input  logic                    wr_req_i,
    input  logic [DATA_W-1:0]       wr_data_i,
    input  logic                    stat_rd_i,
    input  logic [DATA_W-1:0]       rdat_i,
    input  logic                    fill_busy_i,
    input  logic                    flush_busy_i,
    output logic [PTR_W-1:0]        ptr_o,
    output logic                    mem_we_o,
    output logic [PTR_W-1:0]        mem_waddr_o,
    output logic [DATA_W-1:0]       mem_wdata_o,
    output logic                    fill_start_o,
    output logic [CNT_W-1:0]        fill_len_o,
    output logic                    flush_start_o,
    output logic                    ack_o,
    output logic [DATA_W-1:0]       rd_data_o,
    output logic                    req_o,
    output logic [7:0]              bas_o
);
    localparam logic signed [LEN_W-1:0] SECT_L = LEN_W'(SECT_BYTES);
    localparam logic [PTR_W-1:0]        LAST   = PTR_W'(SECT_BYTES - 1);

    typedef struct packed {
        logic [PTR_W-1:0]        ptr;
        logic signed [LEN_W-1:0] len;
        logic                    ack;
        logic [DATA_W-1:0]       rdata;
        logic                    req;
        logic                    pm;
        logic                    dend;
        logic                    dhold;
        logic                    nreq;
    } st_t;

    st_t st_d, st_q;

    logic                    can_serve;
    logic                    rd_ok;
    logic                    wr_ok;
    logic                    rd_take;
    logic                    wr_take;
    logic signed [LEN_W-1:0] ptr_ext;
    logic signed [LEN_W-1:0] len_less;

    function automatic logic [CNT_W-1:0] clamp_len(logic signed [LEN_W-1:0] v);
        if (v >= SECT_L) begin
            return CNT_W'(SECT_BYTES);
        end
        return v[CNT_W-1:0];
    endfunction

    assign can_serve = !st_q.ack && !fill_busy_i && !flush_busy_i && !start_i;
    assign rd_ok     = (phase_i == PH_DATA_IN) || dma_mode_i;
    assign wr_ok     = (phase_i == PH_DATA_OUT) && (init_cmd_i == INIT_DRIVE_DATA);
    assign rd_take   = rd_req_i && can_serve;
    assign wr_take   = wr_req_i && !rd_req_i && can_serve;
    assign ptr_ext   = {{(LEN_W-PTR_W){1'b0}}, st_q.ptr};
    assign len_less  = st_q.len - SECT_L;

    always_comb begin
        st_d          = st_q;
        st_d.ack      = 1'b0;
        mem_we_o      = 1'b0;
        mem_waddr_o   = st_q.ptr;
        mem_wdata_o   = wr_data_i;
        fill_start_o  = 1'b0;
        fill_len_o    = '0;
        flush_start_o = 1'b0;

        if (stat_rd_i) begin
            st_d.nreq = 1'b0;
        end

        if (start_i) begin
            st_d.ptr   = '0;
            st_d.len   = start_len_i;
            st_d.req   = 1'b1;
            st_d.pm    = 1'b1;
            st_d.dend  = 1'b0;
            st_d.dhold = 1'b0;
            st_d.nreq  = 1'b0;
            if (start_len_i > 0 && start_len_i < SECT_L) begin
                mem_we_o    = 1'b1;
                mem_waddr_o = start_len_i[PTR_W-1:0];
                mem_wdata_o = '0;
            end
            if (start_rd_i && start_len_i > 0) begin
                fill_start_o = 1'b1;
                fill_len_o   = clamp_len(start_len_i);
            end
        end else if (rd_take) begin
            st_d.ack = 1'b1;
            if (rd_ok) begin
                st_d.rdata = rdat_i;
                if (st_q.len < SECT_L) begin
                    if (ptr_ext < st_q.len - 1) begin
                        st_d.ptr = st_q.ptr + 1'b1;
                    end else begin
                        st_d.nreq = 1'b1;
                    end
                end else if (st_q.ptr != LAST) begin
                    st_d.ptr = st_q.ptr + 1'b1;
                end else begin
                    st_d.len  = len_less;
                    st_d.ptr  = '0;
                    st_d.nreq = 1'b1;
                    if (len_less > 0) begin
                        fill_start_o = 1'b1;
                        fill_len_o   = clamp_len(len_less);
                    end else begin
                        if (dma_mode_i) begin
                            st_d.dend = 1'b1;
                        end
                        st_d.req = 1'b0;
                        st_d.pm  = 1'b0;
                    end
                end
            end else begin
                st_d.rdata = '0;
            end
        end else if (wr_take) begin
            st_d.ack = 1'b1;
            if (wr_ok) begin
                mem_we_o = 1'b1;
                if (st_q.ptr == LAST) begin
                    flush_start_o = 1'b1;
                    st_d.len      = len_less;
                    st_d.ptr      = '0;
                    if (len_less <= 0) begin
                        st_d.dend  = 1'b1;
                        st_d.dhold = 1'b1;
                        st_d.pm    = 1'b1;
                    end
                end else begin
                    st_d.ptr = st_q.ptr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o     = st_q.ptr;
    assign ack_o     = st_q.ack;
    assign rd_data_o = st_q.rdata;
    assign req_o     = st_q.req && !st_q.nreq && !fill_busy_i;

    always_comb begin
        bas_o              = '0;
        bas_o[BAS_END_BIT] = st_q.dend;
        bas_o[BAS_DMA_BIT] = dma_mode_i || st_q.dhold;
        bas_o[BAS_PM_BIT]  = st_q.pm;
    end

    // R5: reading the last byte of a full sector wraps the pointer and drops the count by a sector
    p_sector_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && rd_ok && st_q.len >= SECT_L && st_q.ptr == LAST)
        |=> (st_q.ptr == '0 && st_q.len == $past(st_q.len) - SECT_L && st_q.nreq));

    // R3: at the short-transfer limit the pointer holds and next-REQ is raised
    p_short_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && rd_ok && st_q.len < SECT_L && ptr_ext >= st_q.len - 1)
        |=> (st_q.ptr == $past(st_q.ptr) && !req_o));

    // R2: a read outside data-in and DMA leaves the pointer alone and returns zero
    p_read_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && !rd_ok) |=> (st_q.ptr == $past(st_q.ptr) && rd_data_o == '0));

    // R6: running out of data on the read side drops REQ and phase match
    p_read_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && rd_ok && st_q.len >= SECT_L && st_q.ptr == LAST && len_less <= 0)
        |=> (!req_o && !bas_o[BAS_PM_BIT]));

    // R10: a final write flush leaves end, DMA and phase-match bits set
    p_write_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_take && wr_ok && st_q.ptr == LAST && len_less <= 0)
        |=> (bas_o[BAS_END_BIT] && bas_o[BAS_DMA_BIT] && bas_o[BAS_PM_BIT]));
endmodule

// File: rtl/sb_xfer.sv
module sb_xfer #(
    parameter int SECT_BYTES = 512,
    parameter int DATA_W     = 8,
    parameter int LEN_W      = 24,
    localparam int PTR_W     = $clog2(SECT_BYTES),
    localparam int CNT_W     = PTR_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic signed [LEN_W-1:0] start_len_i,
    input  logic                    start_rd_i,
    input  logic [2:0]              phase_i,
    input  logic                    dma_mode_i,
    input  logic [7:0]              init_cmd_i,
    input  logic                    rd_req_i,
    input  logic                    wr_req_i,
    input  logic [DATA_W-1:0]       wr_data_i,
    output logic                    ack_o,
    output logic [DATA_W-1:0]       rd_data_o,
    input  logic                    stat_rd_i,
    output logic                    req_o,
    output logic [7:0]              bas_o,
    output logic                    fill_req_o,
    output logic [CNT_W-1:0]        fill_len_o,
    input  logic                    fill_valid_i,
    input  logic [DATA_W-1:0]       fill_data_i,
    input  logic                    fill_ack_i,
    output logic                    flush_req_o,
    input  logic [PTR_W-1:0]        flush_addr_i,
    output logic [DATA_W-1:0]       flush_data_o,
    input  logic                    flush_ack_i
);
    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] rdat;
    logic              c_we;
    logic [PTR_W-1:0]  c_waddr;
    logic [DATA_W-1:0] c_wdata;
    logic              s_we;
    logic [PTR_W-1:0]  s_waddr;
    logic [DATA_W-1:0] s_wdata;
    logic              fill_start;
    logic [CNT_W-1:0]  fill_len_req;
    logic              flush_start;

    sb_ctrl #(.SECT_BYTES(SECT_BYTES), .DATA_W(DATA_W), .LEN_W(LEN_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .start_len_i(start_len_i), .start_rd_i(start_rd_i),
        .phase_i(phase_i), .dma_mode_i(dma_mode_i), .init_cmd_i(init_cmd_i),
        .rd_req_i(rd_req_i), .wr_req_i(wr_req_i), .wr_data_i(wr_data_i),
        .stat_rd_i(stat_rd_i), .rdat_i(rdat),
        .fill_busy_i(fill_req_o), .flush_busy_i(flush_req_o),
        .ptr_o(ptr), .mem_we_o(c_we), .mem_waddr_o(c_waddr), .mem_wdata_o(c_wdata),
        .fill_start_o(fill_start), .fill_len_o(fill_len_req), .flush_start_o(flush_start),
        .ack_o(ack_o), .rd_data_o(rd_data_o), .req_o(req_o), .bas_o(bas_o)
    );

    sb_storage_if #(.SECT_BYTES(SECT_BYTES), .DATA_W(DATA_W)) i_stor (
        .clk(clk), .rst_n(rst_n),
        .fill_start_i(fill_start), .fill_len_i(fill_len_req),
        .fill_valid_i(fill_valid_i), .fill_data_i(fill_data_i), .fill_ack_i(fill_ack_i),
        .flush_start_i(flush_start), .flush_ack_i(flush_ack_i),
        .fill_req_o(fill_req_o), .fill_len_o(fill_len_o), .flush_req_o(flush_req_o),
        .mem_we_o(s_we), .mem_waddr_o(s_waddr), .mem_wdata_o(s_wdata)
    );

    sb_buffer #(.DEPTH(SECT_BYTES), .DATA_W(DATA_W)) i_buf (
        .clk(clk),
        .a_we_i(c_we), .a_addr_i(c_waddr), .a_data_i(c_wdata),
        .b_we_i(s_we), .b_addr_i(s_waddr), .b_data_i(s_wdata),
        .r0_addr_i(ptr), .r0_data_o(rdat),
        .r1_addr_i(flush_addr_i), .r1_data_o(flush_data_o)
    );

    // R7: no acknowledge in the cycle after a pending fill
    p_fill_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_o |=> !ack_o);

    // R7: REQ is low while a fill is outstanding
    p_fill_req_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_o |-> !req_o);

    // R9: no acknowledge in the cycle after a pending flush
    p_flush_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req_o |=> !ack_o);
endmodule

// File: tb/test_sb_xfer.sv
module test_sb_xfer;
    localparam int CLK_PERIOD = 10;
    localparam int SECT  = 512;
    localparam int LEN_W = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic signed [LEN_W-1:0] start_len_i = '0;
    logic start_rd_i = 1'b0;
    logic [2:0] phase_i = 3'd0;
    logic dma_mode_i = 1'b0;
    logic [7:0] init_cmd_i = 8'h00;
    logic rd_req_i = 1'b0;
    logic wr_req_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic ack_o;
    logic [7:0] rd_data_o;
    logic stat_rd_i = 1'b0;
    logic req_o;
    logic [7:0] bas_o;
    logic fill_req_o;
    logic [9:0] fill_len_o;
    logic fill_valid_i = 1'b0;
    logic [7:0] fill_data_i = 8'h00;
    logic fill_ack_i = 1'b0;
    logic flush_req_o;
    logic [8:0] flush_addr_i = '0;
    logic [7:0] flush_data_o;
    logic flush_ack_i = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sb_xfer i_sb_xfer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_len_i(start_len_i),
        .start_rd_i(start_rd_i), .phase_i(phase_i), .dma_mode_i(dma_mode_i),
        .init_cmd_i(init_cmd_i), .rd_req_i(rd_req_i), .wr_req_i(wr_req_i),
        .wr_data_i(wr_data_i), .ack_o(ack_o), .rd_data_o(rd_data_o),
        .stat_rd_i(stat_rd_i), .req_o(req_o), .bas_o(bas_o),
        .fill_req_o(fill_req_o), .fill_len_o(fill_len_o), .fill_valid_i(fill_valid_i),
        .fill_data_i(fill_data_i), .fill_ack_i(fill_ack_i), .flush_req_o(flush_req_o),
        .flush_addr_i(flush_addr_i), .flush_data_o(flush_data_o), .flush_ack_i(flush_ack_i)
    );

    function automatic logic [7:0] fpat(int sec, int i);
        return 8'((i * 5) + (sec * 17) + 3);
    endfunction

    function automatic logic [7:0] wpat(int i);
        return 8'((i * 3) + 1);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd_byte(output logic [7:0] b, output bit got);
        got = 1'b0;
        b = 8'h00;
        rd_req_i = 1'b1;
        for (int k = 0; k < 40 && !got; k++) begin
            @(negedge clk);
            if (ack_o) begin
                got = 1'b1;
                b = rd_data_o;
            end
        end
        rd_req_i = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] v, output bit got);
        got = 1'b0;
        wr_data_i = v;
        wr_req_i = 1'b1;
        for (int k = 0; k < 40 && !got; k++) begin
            @(negedge clk);
            if (ack_o) got = 1'b1;
        end
        wr_req_i = 1'b0;
    endtask

    task automatic start_xfer(input int len, input bit rd);
        start_len_i = LEN_W'(len);
        start_rd_i = rd;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic do_fill(input int n, input int sec);
        for (int i = 0; i < n; i++) begin
            fill_valid_i = 1'b1;
            fill_data_i = fpat(sec, i);
            @(negedge clk);
        end
        fill_valid_i = 1'b0;
        fill_ack_i = 1'b1;
        @(negedge clk);
        fill_ack_i = 1'b0;
    endtask

    task automatic peek(input int a, output logic [7:0] v);
        flush_addr_i = 9'(a);
        #1;
        v = flush_data_o;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!ack_o && !fill_req_o && !flush_req_o && !req_o, "R1 handshake idle", {ack_o, fill_req_o, flush_req_o, req_o}, 0);
        chk(bas_o == 8'h00, "R1 status clear", bas_o, 8'h00);
    endtask

    task automatic t_write_sector();
        bit got;
        int bad;
        logic [7:0] v;
        phase_i = 3'd0; init_cmd_i = 8'h01; dma_mode_i = 1'b0;
        start_xfer(512, 1'b0);
        chk(req_o == 1'b1, "R11 REQ after start", req_o, 1);
        chk(bas_o == 8'h08, "R11 status after start", bas_o, 8'h08);
        bad = 0;
        for (int i = 0; i < SECT - 1; i++) begin
            wr_byte(wpat(i), got);
            if (!got || flush_req_o) bad++;
        end
        chk(bad == 0, "R8 writes accepted without early flush", bad, 0);
        wr_byte(wpat(SECT - 1), got);
        chk(got && flush_req_o, "R9 flush after byte 511", flush_req_o, 1);
        chk(bas_o == 8'hC8, "R10 status after final flush", bas_o, 8'hC8);
        // pending write during flush, with capture disabled
        init_cmd_i = 8'h03;
        wr_data_i = 8'hEE;
        wr_req_i = 1'b1;
        bad = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (ack_o) bad++;
        end
        chk(bad == 0, "R9 write stalls during flush", bad, 0);
        bad = 0;
        for (int i = 0; i < SECT; i++) begin
            peek(i, v);
            if (v !== wpat(i)) bad++;
        end
        chk(bad == 0, "R8 flushed sector content", bad, 0);
        flush_ack_i = 1'b1;
        @(negedge clk);
        flush_ack_i = 1'b0;
        got = 1'b0;
        for (int k = 0; k < 10 && !got; k++) begin
            @(negedge clk);
            if (ack_o) got = 1'b1;
        end
        wr_req_i = 1'b0;
        chk(got, "R9 write released after flush ack", got, 1);
        peek(0, v);
        chk(v == wpat(0), "R8 ignored write left buffer", v, wpat(0));
        init_cmd_i = 8'h01;
        phase_i = 3'd2;
        wr_byte(8'h55, got);
        peek(1, v);
        chk(got && v == wpat(1), "R8 wrong-phase write ignored", v, wpat(1));
    endtask

    task automatic t_short_read();
        bit got;
        int bad;
        logic [7:0] v;
        phase_i = 3'd1; dma_mode_i = 1'b0;
        start_xfer(5, 1'b1);
        chk(fill_req_o && fill_len_o == 10'd5, "R5 initial short fill length", fill_len_o, 5);
        chk(req_o == 1'b0, "R7 REQ low while fill pending", req_o, 0);
        do_fill(5, 9);
        peek(5, v);
        chk(v == 8'h00, "R4 pad byte past data", v, 8'h00);
        peek(4, v);
        chk(v == fpat(9, 4), "R4 last valid byte intact", v, fpat(9, 4));
        chk(req_o == 1'b1, "R11 REQ after fill", req_o, 1);
        // wrong phase read
        phase_i = 3'd2;
        rd_byte(v, got);
        chk(got && v == 8'h00, "R2 read outside data-in gives zero", v, 8'h00);
        phase_i = 3'd1;
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            rd_byte(v, got);
            if (!got || v !== fpat(9, i)) bad++;
        end
        chk(bad == 0, "R2 data-in reads in order, pointer kept by ignored read", bad, 0);
        chk(req_o == 1'b0, "R3 next-REQ masks REQ at last byte", req_o, 0);
        rd_byte(v, got);
        chk(got && v == fpat(9, 4), "R3 pointer holds at length-1", v, fpat(9, 4));
        stat_rd_i = 1'b1;
        @(negedge clk);
        stat_rd_i = 1'b0;
        chk(req_o == 1'b1, "R3 status read clears next-REQ", req_o, 1);
    endtask

    task automatic t_stall_and_multi();
        bit got;
        int bad;
        logic [7:0] v;
        phase_i = 3'd1; dma_mode_i = 1'b0;
        start_xfer(700, 1'b1);
        chk(fill_len_o == 10'd512, "R5 first fill clamps to sector", fill_len_o, 512);
        rd_req_i = 1'b1;
        bad = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (ack_o || req_o) bad++;
        end
        rd_req_i = 1'b0;
        chk(bad == 0, "R7 read stalls while fill pending", bad, 0);
        do_fill(512, 1);
        bad = 0;
        for (int i = 0; i < SECT; i++) begin
            rd_byte(v, got);
            if (!got || v !== fpat(1, i)) bad++;
        end
        chk(bad == 0, "R2 full sector read data", bad, 0);
        chk(fill_req_o && fill_len_o == 10'd188, "R5 refill of remaining bytes", fill_len_o, 188);
        do_fill(188, 2);
        rd_byte(v, got);
        chk(got && v == fpat(2, 0), "R5 pointer wrapped to zero", v, fpat(2, 0));
    endtask

    task automatic t_dma_end();
        bit got;
        int bad;
        logic [7:0] v;
        phase_i = 3'd3; dma_mode_i = 1'b1;
        start_xfer(1024, 1'b1);
        do_fill(512, 4);
        bad = 0;
        for (int i = 0; i < SECT; i++) begin
            rd_byte(v, got);
            if (!got || v !== fpat(4, i)) bad++;
        end
        chk(bad == 0, "R2 DMA-mode reads in non-data phase", bad, 0);
        chk(fill_req_o && fill_len_o == 10'd512, "R5 second sector fill", fill_len_o, 512);
        chk(bas_o == 8'h48, "R6 no end before last sector", bas_o, 8'h48);
        do_fill(512, 5);
        bad = 0;
        for (int i = 0; i < SECT; i++) begin
            rd_byte(v, got);
            if (!got || v !== fpat(5, i)) bad++;
        end
        chk(bad == 0, "R5 second sector data", bad, 0);
        chk(bas_o == 8'hC0, "R6 end set, phase match cleared", bas_o, 8'hC0);
        chk(!req_o && !fill_req_o, "R6 REQ low and no refill at end", {req_o, fill_req_o}, 0);
        stat_rd_i = 1'b1;
        @(negedge clk);
        stat_rd_i = 1'b0;
        chk(req_o == 1'b0, "R6 REQ stays low after status read", req_o, 0);
        dma_mode_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_sector();
        t_short_read();
        t_stall_and_multi();
        t_dma_end();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule